// File: doc/BRIEF.md
# Slave-Serial Configuration Loader

This block drives a programmable-logic target through a slave-serial configuration load. It starts when `start` pulses. It holds the target's reset line low for a fixed number of cycles and then releases it. It then waits for the target's ready input to rise, with a bounded poll window. After a short settling interval it begins to accept bytes from an upstream source.

The bytes arriving on the input stream are scanned for a sync header. Everything before the header is thrown away. The header is an all-ones byte followed by a byte whose upper four bits are `0x2`. When the header is found, an all-ones byte is sent first and then the matching byte. From then on every byte is sent unchanged. Each byte is serialized most significant bit first on a data pin, with a generated serial clock. The target samples the data on the clock's rising edge.

The input is a valid/ready stream. A byte is taken on a clock edge where both `in_valid` and `in_ready` are high. While a byte is being shifted out, the source is held off. `in_last` marks the final byte of the image. `done` pulses once that byte has left the serializer.

Top module: `cfg_serial_loader`

## Requirements
- R1: After reset, `tgt_rst_n` is 1, `tgt_clk` is 0, and `busy`, `done`, `err_timeout` and `in_ready` are all 0.
- R2: A `start` pulse drives `tgt_rst_n` low for exactly PULSE_CYC cycles and then high again. `busy` is high throughout the load. A `start` pulse in any state restarts the whole sequence and clears `err_timeout`.
- R3: While the target's ready input `tgt_ready` is low after the pulse, `in_ready` stays 0 and `tgt_clk` stays low. Input is accepted only after `tgt_ready` has been seen high and SETTLE_CYC further cycles have passed.
- R4: If `tgt_ready` stays low for POLL_LIMIT cycles, `err_timeout` goes to 1 and stays at 1 until the next `start`. In that state `busy` is 0, `tgt_rst_n` is 1, and no serial clock is produced.
- R5: Before sync, every accepted byte other than 0xFF is discarded and produces no serial clock.
- R6: After a 0xFF, a byte whose bits [7:4] equal 4'h2 causes 0xFF and then that byte to be sent. Any other byte, including a second 0xFF, returns the block to searching and sends nothing.
- R7: Once synced, every accepted byte is sent unchanged, eight bits, most significant bit first, in order of arrival.
- R8: Each bit is placed on `tgt_data` while `tgt_clk` is low. `tgt_clk` then stays high for exactly HALF_DIV cycles, with `tgt_data` stable. The low time between rising edges is at least HALF_DIV cycles.
- R9: `in_ready` is high whenever the block is in the sync-search states. Once synced, it is high only when the serializer is empty and no byte is waiting. The inserted 0xFF does not consume an input byte.
- R10: `done` is a one-cycle pulse after the last bit of the byte marked by `in_last` has been clocked out. `busy` then drops. If the marked byte is discarded before sync, the load ends at once with the same pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin (or restart) a load |
| in_data | input | 8 | Image byte |
| in_valid | input | 1 | `in_data` is valid |
| in_last | input | 1 | Marks the final image byte |
| in_ready | output | 1 | Loader accepts the byte this cycle |
| tgt_ready | input | 1 | Target's ready indication (asynchronous) |
| tgt_rst_n | output | 1 | Target configuration reset, active low |
| tgt_clk | output | 1 | Serial clock; target samples on rising edge |
| tgt_data | output | 1 | Serial data |
| busy | output | 1 | A load is in progress |
| done | output | 1 | One-cycle end-of-load pulse |
| err_timeout | output | 1 | Target never became ready; held until next start |

## Verification
The bench builds the loader with PULSE_CYC=5, POLL_LIMIT=50, SETTLE_CYC=3 and HALF_DIV=2. The short poll limit brings the timeout path and the restart out of the error state within a few dozen cycles. The divider of 2 makes the clock-width checks sensitive to one-cycle errors. It also keeps whole multi-byte images short enough to run several header patterns in one run: false syncs, a doubled 0xFF, and a last byte that falls before sync.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;
  typedef logic [7:0] byte_t;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_PULSE,
    SQ_WAIT,
    SQ_SETTLE,
    SQ_RUN,
    SQ_ERR
  } seq_state_t;

  typedef enum logic [1:0] {
    HS_SEARCH,
    HS_ARMED,
    HS_PASS
  } hdr_state_t;

  localparam byte_t SYNC_LEAD = 8'hFF;
  localparam logic [3:0] SYNC_NIBBLE = 4'h2;
endpackage

// File: rtl/cfg_prog_seq.sv
module cfg_prog_seq
  import cfg_loader_pkg::*;
#(
  parameter int PULSE_CYC  = 16,   // must be at least 2 (covers the ready synchronizer)
  parameter int POLL_LIMIT = 60000,
  parameter int SETTLE_CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic ready_raw,
  input  logic stream_end,
  output logic tgt_rst_n,
  output logic running,
  output logic busy,
  output logic err_timeout,
  output logic done
);
  localparam int MAXC = (POLL_LIMIT > PULSE_CYC) ?
                        ((POLL_LIMIT > SETTLE_CYC) ? POLL_LIMIT : SETTLE_CYC) :
                        ((PULSE_CYC > SETTLE_CYC) ? PULSE_CYC : SETTLE_CYC);
  localparam int CW = $clog2(MAXC + 1);

  seq_state_t st;
  logic [CW-1:0] cnt;
  logic [1:0] rdy_sync;
  logic done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdy_sync <= '0;
    else        rdy_sync <= {rdy_sync[0], ready_raw};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= SQ_IDLE;
      cnt    <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start) begin
        st  <= SQ_PULSE;
        cnt <= '0;
      end else begin
        unique case (st)
          SQ_PULSE: begin
            if (cnt == CW'(PULSE_CYC - 1)) begin
              st  <= SQ_WAIT;
              cnt <= '0;
            end else cnt <= cnt + 1'b1;
          end
          SQ_WAIT: begin
            if (rdy_sync[1]) begin
              st  <= (SETTLE_CYC == 0) ? SQ_RUN : SQ_SETTLE;
              cnt <= '0;
            end else if (cnt == CW'(POLL_LIMIT - 1)) begin
              st <= SQ_ERR;
            end else cnt <= cnt + 1'b1;
          end
          SQ_SETTLE: begin
            if (cnt == CW'(SETTLE_CYC - 1)) st <= SQ_RUN;
            else cnt <= cnt + 1'b1;
          end
          SQ_RUN: begin
            if (stream_end) begin
              st     <= SQ_IDLE;
              done_q <= 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign tgt_rst_n   = (st != SQ_PULSE);
  assign running     = (st == SQ_RUN);
  assign busy        = (st != SQ_IDLE) && (st != SQ_ERR);
  assign err_timeout = (st == SQ_ERR);
  assign done        = done_q;
endmodule

// File: rtl/cfg_sync_filter.sv
module cfg_sync_filter
  import cfg_loader_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  enable,
  input  byte_t in_data,
  input  logic  in_valid,
  input  logic  in_last,
  output logic  in_ready,
  input  logic  sh_empty,
  output logic  sh_load,
  output byte_t sh_byte,
  output logic  sh_last,
  output logic  stream_end
);
  hdr_state_t st;
  logic  hold_v;
  byte_t hold_b;
  logic  hold_l;
  logic  accept;
  logic  hit;

  assign hit      = (in_data[7:4] == SYNC_NIBBLE);
  assign in_ready = enable && ((st != HS_PASS) || (sh_empty && !hold_v));
  assign accept   = in_valid && in_ready;

  always_comb begin
    sh_load    = 1'b0;
    sh_byte    = '0;
    sh_last    = 1'b0;
    stream_end = 1'b0;
    if (enable) begin
      unique case (st)
        HS_SEARCH: stream_end = accept && in_last;
        HS_ARMED: begin
          if (accept && hit) begin
            sh_load = 1'b1;
            sh_byte = SYNC_LEAD;
          end else begin
            stream_end = accept && in_last;
          end
        end
        default: begin
          if (hold_v && sh_empty) begin
            sh_load = 1'b1;
            sh_byte = hold_b;
            sh_last = hold_l;
          end else if (accept) begin
            sh_load = 1'b1;
            sh_byte = in_data;
            sh_last = in_last;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= HS_SEARCH;
      hold_v <= 1'b0;
      hold_b <= '0;
      hold_l <= 1'b0;
    end else if (!enable) begin
      st     <= HS_SEARCH;
      hold_v <= 1'b0;
    end else begin
      unique case (st)
        HS_SEARCH: if (accept && in_data == SYNC_LEAD) st <= HS_ARMED;
        HS_ARMED: begin
          if (accept) begin
            if (hit) begin
              st     <= HS_PASS;
              hold_v <= 1'b1;
              hold_b <= in_data;
              hold_l <= in_last;
            end else st <= HS_SEARCH;
          end
        end
        default: if (hold_v && sh_empty) hold_v <= 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/cfg_bit_shifter.sv
module cfg_bit_shifter
  import cfg_loader_pkg::*;
#(
  parameter int HALF_DIV = 4
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  flush,
  input  logic  load,
  input  byte_t load_byte,
  input  logic  load_last,
  output logic  empty,
  output logic  fin,
  output logic  ser_clk,
  output logic  ser_data
);
  localparam int HW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic          active;
  byte_t         sr;
  logic [2:0]    nbit;
  logic          phase_hi;
  logic [HW-1:0] cnt;
  logic          tag_last;
  logic          phase_end;

  assign phase_end = active && (cnt == HW'(HALF_DIV - 1));
  assign empty     = !active;
  assign fin       = phase_end && phase_hi && (nbit == 3'd0) && tag_last && !flush;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active   <= 1'b0;
      sr       <= '0;
      nbit     <= '0;
      phase_hi <= 1'b0;
      cnt      <= '0;
      tag_last <= 1'b0;
    end else if (flush) begin
      active   <= 1'b0;
      phase_hi <= 1'b0;
      cnt      <= '0;
    end else if (!active) begin
      if (load) begin
        active   <= 1'b1;
        sr       <= load_byte;
        nbit     <= 3'd7;
        phase_hi <= 1'b0;
        cnt      <= '0;
        tag_last <= load_last;
      end
    end else if (phase_end) begin
      cnt <= '0;
      if (!phase_hi) begin
        phase_hi <= 1'b1;
      end else begin
        phase_hi <= 1'b0;
        if (nbit == 3'd0) active <= 1'b0;
        else begin
          sr   <= {sr[6:0], 1'b0};
          nbit <= nbit - 1'b1;
        end
      end
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign ser_clk  = active && phase_hi;
  assign ser_data = active && sr[7];
endmodule

// File: rtl/cfg_serial_loader.sv
module cfg_serial_loader
  import cfg_loader_pkg::*;
#(
  parameter int PULSE_CYC  = 16,
  parameter int POLL_LIMIT = 60000,
  parameter int SETTLE_CYC = 8,
  parameter int HALF_DIV   = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] in_data,
  input  logic       in_valid,
  input  logic       in_last,
  output logic       in_ready,
  input  logic       tgt_ready,
  output logic       tgt_rst_n,
  output logic       tgt_clk,
  output logic       tgt_data,
  output logic       busy,
  output logic       done,
  output logic       err_timeout
);
  logic  running;
  logic  sh_empty, sh_load, sh_last, sh_fin;
  byte_t sh_byte;
  logic  hdr_end;

  cfg_prog_seq #(
    .PULSE_CYC (PULSE_CYC),
    .POLL_LIMIT(POLL_LIMIT),
    .SETTLE_CYC(SETTLE_CYC)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .ready_raw  (tgt_ready),
    .stream_end (hdr_end | sh_fin),
    .tgt_rst_n  (tgt_rst_n),
    .running    (running),
    .busy       (busy),
    .err_timeout(err_timeout),
    .done       (done)
  );

  cfg_sync_filter u_hdr (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (running),
    .in_data   (in_data),
    .in_valid  (in_valid),
    .in_last   (in_last),
    .in_ready  (in_ready),
    .sh_empty  (sh_empty),
    .sh_load   (sh_load),
    .sh_byte   (sh_byte),
    .sh_last   (sh_last),
    .stream_end(hdr_end)
  );

  cfg_bit_shifter #(
    .HALF_DIV(HALF_DIV)
  ) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .flush    (!running),
    .load     (sh_load),
    .load_byte(sh_byte),
    .load_last(sh_last),
    .empty    (sh_empty),
    .fin      (sh_fin),
    .ser_clk  (tgt_clk),
    .ser_data (tgt_data)
  );
endmodule

// File: rtl/cfg_serial_loader_chk.sv
module cfg_serial_loader_chk (
  input logic clk,
  input logic rst_n,
  input logic tgt_rst_n,
  input logic tgt_clk,
  input logic tgt_data,
  input logic in_ready,
  input logic busy,
  input logic done,
  input logic err_timeout
);
  AST_PULSE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !tgt_rst_n |-> busy);  // R2
  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    err_timeout |-> (tgt_rst_n && !tgt_clk && !busy && !in_ready));  // R4
  AST_IDLE_NO_CLK: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!tgt_clk && !in_ready));  // R3
  AST_READY_AFTER_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (busy && tgt_rst_n));  // R9
  AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_clk && $past(tgt_clk)) |-> $stable(tgt_data));  // R8
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);  // R10
endmodule

bind cfg_serial_loader cfg_serial_loader_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tgt_rst_n  (tgt_rst_n),
  .tgt_clk    (tgt_clk),
  .tgt_data   (tgt_data),
  .in_ready   (in_ready),
  .busy       (busy),
  .done       (done),
  .err_timeout(err_timeout)
);

// File: tb/cfg_serial_loader_test.sv
`timescale 1ns/1ps
module cfg_serial_loader_test;
  localparam int PULSE_CYC  = 5;
  localparam int POLL_LIMIT = 50;
  localparam int SETTLE_CYC = 3;
  localparam int HALF_DIV   = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [7:0] in_data = '0;
  logic in_valid = 1'b0;
  logic in_last = 1'b0;
  logic in_ready;
  logic tgt_ready = 1'b0;
  logic tgt_rst_n, tgt_clk, tgt_data, busy, done, err_timeout;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  cfg_serial_loader #(
    .PULSE_CYC(PULSE_CYC), .POLL_LIMIT(POLL_LIMIT),
    .SETTLE_CYC(SETTLE_CYC), .HALF_DIV(HALF_DIV)
  ) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .in_data(in_data),
    .in_valid(in_valid), .in_last(in_last), .in_ready(in_ready),
    .tgt_ready(tgt_ready), .tgt_rst_n(tgt_rst_n), .tgt_clk(tgt_clk),
    .tgt_data(tgt_data), .busy(busy), .done(done), .err_timeout(err_timeout)
  );

  // serial capture and clock-shape monitor, sampled on the falling edge
  logic [7:0] cap [0:31];
  int cap_n = 0;
  logic [7:0] acc = '0;
  int nb = 0;
  logic prev_clk = 1'b0;
  logic prev_data = 1'b0;
  int hi_cnt = 0;
  int lo_cnt = 1000;
  int shape_err = 0;
  int bp_err = 0;
  int done_cnt = 0;

  always @(negedge clk) begin
    if (done) done_cnt++;
    if (tgt_clk && in_ready) bp_err++;
    if (tgt_clk && !prev_clk) begin
      if (lo_cnt < HALF_DIV) shape_err++;
      acc = {acc[6:0], tgt_data};
      nb++;
      if (nb == 8) begin
        if (cap_n < 32) cap[cap_n] = acc;
        cap_n++;
        nb = 0;
      end
      hi_cnt = 1;
    end else if (tgt_clk) begin
      hi_cnt++;
      if (tgt_data != prev_data) shape_err++;
    end else begin
      if (prev_clk && hi_cnt != HALF_DIV) shape_err++;
      lo_cnt = prev_clk ? 1 : lo_cnt + 1;
    end
    prev_clk  = tgt_clk;
    prev_data = tgt_data;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_mon();
    cap_n = 0; nb = 0; shape_err = 0; bp_err = 0; done_cnt = 0;
  endtask

  task automatic send(input logic [7:0] b, input bit l);
    @(negedge clk);
    in_valid = 1'b1; in_data = b; in_last = l;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
  endtask

  // start, check pulse width, raise ready, wait for input acceptance
  task automatic bring_up();
    int lo;
    tgt_ready = 1'b0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    lo = 0;
    while (!tgt_rst_n && lo < 100) begin lo++; @(negedge clk); end
    chk(lo == PULSE_CYC, "R2 pulse width", lo, PULSE_CYC);
    chk(busy == 1'b1, "R2 busy during load", busy, 1);
    repeat (10) @(negedge clk);
    chk(!in_ready && !tgt_clk, "R3 held while target not ready", in_ready, 0);
    tgt_ready = 1'b1;
    lo = 0;
    while (!in_ready && lo < 100) begin lo++; @(negedge clk); end
    // 2 sync stages + 1 wait-exit + settle cycles
    chk(lo >= SETTLE_CYC + 2, "R3 settle before input", lo, SETTLE_CYC + 2);
  endtask

  task automatic wait_done();
    int n = 0;
    while (done_cnt == 0 && n < 2000) begin n++; @(negedge clk); end
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk(tgt_rst_n && !tgt_clk && !busy && !done && !err_timeout && !in_ready,
        "R1 reset state", {tgt_rst_n, tgt_clk, busy, done, err_timeout, in_ready}, 6'b100000);
  endtask

  task automatic t_timeout();
    int n = 0;
    clear_mon();
    tgt_ready = 1'b0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    while (!err_timeout && n < 500) begin n++; @(negedge clk); end
    // pulse + poll window, plus the cycle of reaching the error state
    chk(n == PULSE_CYC + POLL_LIMIT, "R4 timeout latency", n, PULSE_CYC + POLL_LIMIT);
    repeat (20) @(negedge clk);
    chk(err_timeout && !busy && tgt_rst_n, "R4 error held", {err_timeout, busy, tgt_rst_n}, 3'b101);
    chk(cap_n == 0 && nb == 0, "R4 no serial clocks", cap_n, 0);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(!err_timeout && !tgt_rst_n, "R2 restart clears error", err_timeout, 0);
    tgt_ready = 1'b1;
    repeat (PULSE_CYC + SETTLE_CYC + 6) @(negedge clk);
    chk(in_ready == 1'b1, "R9 ready in search after restart", in_ready, 1);
    send(8'h77, 1'b1);   // discarded before sync, ends the load
    wait_done();
  endtask

  task automatic t_basic();
    logic [7:0] exp [4] = '{8'hFF, 8'h25, 8'hA5, 8'h3C};
    clear_mon();
    bring_up();
    send(8'h11, 0); send(8'h00, 0);
    chk(cap_n == 0 && nb == 0, "R5 junk discarded", nb, 0);
    send(8'hFF, 0); send(8'h25, 0); send(8'hA5, 0); send(8'h3C, 1);
    wait_done();
    chk(cap_n == 4, "R6 byte count", cap_n, 4);
    for (int i = 0; i < 4; i++)
      chk(cap[i] == exp[i], "R7 byte value", cap[i], exp[i]);
    chk(done_cnt == 1, "R10 single done", done_cnt, 1);
    chk(!busy, "R10 busy drops", busy, 0);
    chk(shape_err == 0, "R8 clock shape", shape_err, 0);
    chk(bp_err == 0, "R9 ready low while shifting", bp_err, 0);
  endtask

  task automatic t_false_sync();
    logic [7:0] exp [3] = '{8'hFF, 8'h2B, 8'h01};
    clear_mon();
    bring_up();
    send(8'hFF, 0); send(8'h31, 0);
    send(8'hFF, 0); send(8'hFF, 0);
    send(8'h20, 0);
    chk(cap_n == 0 && nb == 0, "R6 false header emits nothing", cap_n, 0);
    send(8'hFF, 0); send(8'h2B, 0); send(8'h01, 1);
    wait_done();
    chk(cap_n == 3, "R6 byte count after resync", cap_n, 3);
    for (int i = 0; i < 3; i++)
      chk(cap[i] == exp[i], "R7 byte value after resync", cap[i], exp[i]);
    chk(shape_err == 0 && bp_err == 0, "R8 shape and backpressure", shape_err + bp_err, 0);
  endtask

  task automatic t_last_on_header();
    clear_mon();
    bring_up();
    send(8'hFF, 0); send(8'h2E, 1);
    wait_done();
    chk(cap_n == 2 && cap[0] == 8'hFF && cap[1] == 8'h2E, "R9 inserted lead uses no input",
        {cap[0], cap[1]}, 16'hFF2E);
    chk(done_cnt == 1 && !busy, "R10 done after header byte", done_cnt, 1);
  endtask

  task automatic t_last_discarded();
    clear_mon();
    bring_up();
    send(8'h44, 1);
    repeat (3) @(negedge clk);
    chk(done_cnt == 1 && !busy, "R10 discarded last ends load", done_cnt, 1);
    chk(cap_n == 0 && nb == 0, "R5 discarded last no clocks", nb, 0);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_false_sync();
    t_timeout();
    t_last_on_header();
    t_last_discarded();
    summary();
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 100000, 0);
    summary();
  end
endmodule